// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Status Flags

This block turns characters written by a host into asynchronous-style serial frames on a single output line. A frame begins with a low start bit. Then come 5 to 9 data bits, least significant first, an optional parity bit, and one or two high stop bits. A one-entry holding register sits in front of the shift register, so the host can queue the next character while the current one is on the line. The held character moves into the shifter at the very end of the last stop bit, and the line has no idle gap between frames.

Bit timing has two sources. In asynchronous mode each bit lasts a fixed number of baud ticks. In synchronous mode the line advances by one bit on each rising edge of an external serial clock, seen through a synchronizer. Two sticky status flags report the block's state: holding-register-empty and transmit-complete. Each flag drives its own interrupt line, gated by a per-flag enable and by a global enable.

The shifter is a state machine with six states. `ST_IDLE` holds the line high. `ST_START` drives the start bit. `ST_DATA` shifts out the data bits. `ST_PARITY` drives the parity bit. `ST_STOP1` and `ST_STOP2` drive the stop bits. Its transitions are:
- **idle→start**: the block is enabled and the holding register is full.
- **start→data**: bit strobe.
- **data→parity**: strobe on the last data bit with parity on.
- **data→stop1**: strobe on the last data bit with parity off.
- **parity→stop1**: bit strobe.
- **stop1→stop2**: strobe with two stop bits selected.
- **last stop→start**: strobe while the block is enabled and the holding register is full (back-to-back frames).
- **last stop→idle**: strobe otherwise.

Top module: `dbuf_utx`

## Requirements
- R1: A frame is a 0 start bit, then N data bits LSB first, then the parity bit if `par_en`=1, then one stop bit (1), or two stop bits when `two_stop`=1. N is 5+`len_sel` for `len_sel` 0..3 and 9 for `len_sel` 4..7.
- R2: The parity bit is the XOR of the N data bits, XOR-ed with `par_odd`: 0 gives even parity, 1 gives odd parity.
- R3: In asynchronous mode (`sync_mode`=0) every bit lasts OVERSAMPLE (16) `baud_tick` pulses. In synchronous mode a bit ends on the cycle after the second synchronizer stage first shows a rising edge of `sclk_in`.
- R4: A character in the holding register loads into the shifter on the next clock edge if the shifter is idle. If a frame is running, it loads on the edge that ends the last stop bit, and the next start bit follows with no gap.
- R5: `wbit8` is captured with `wdata` on the `wr_data` cycle and becomes data bit 8 in 9-bit frames. Later changes to `wbit8` do not affect that character.
- R6: `dre` is 1 after reset. It is 0 from the edge after a write. It sets on the edge that moves the holding register into the shifter. A status write with `st_wdre`=0 clears it. A status write with `st_wdre`=1 does not set it.
- R7: `txc` sets on the edge that ends a frame while the holding register is empty. It clears on `txc_ack` or on a status write with `st_wtxc`=0. A status write with `st_wtxc`=1 does not set it. Setting wins over clearing.
- R8: `irq_dre` = `dre` & `dre_ie` & `gie`, and `irq_txc` = `txc` & `txc_ie` & `gie`.
- R9: With `tx_en`=0 no new frame starts and the line stays high, but a frame already under way runs to its last stop bit.
- R10: A write while the holding register is full replaces the held character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| sync_mode | input | 1 | 1: bits advance on `sclk_in` edges; 0: on baud ticks |
| len_sel | input | 3 | Character length select (see R1) |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | Odd parity when 1 |
| two_stop | input | 1 | Two stop bits when 1 |
| baud_tick | input | 1 | One-cycle oversampling tick |
| sclk_in | input | 1 | External serial clock (asynchronous) |
| wr_data | input | 1 | Write strobe for the holding register |
| wdata | input | 8 | Character bits 7..0 |
| wbit8 | input | 1 | Character bit 8 |
| st_wr | input | 1 | Status write strobe |
| st_wdre | input | 1 | Value written to the empty flag (only 0 acts) |
| st_wtxc | input | 1 | Value written to the complete flag (only 0 acts) |
| txc_ack | input | 1 | Interrupt acknowledge for the complete flag |
| dre_ie | input | 1 | Empty-flag interrupt enable |
| txc_ie | input | 1 | Complete-flag interrupt enable |
| gie | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial output |
| dre | output | 1 | Holding-register-empty flag |
| txc | output | 1 | Transmit-complete flag |
| irq_dre | output | 1 | Empty-flag interrupt |
| irq_txc | output | 1 | Complete-flag interrupt |

## Verification
The embedded assertions check, on every cycle, the flag rules that look back one edge. These are: a write clears `dre`, writing 1 cannot set a flag, acknowledge clears `txc`, and a frame ending with an empty holding register sets `txc`. They also check that a load always finds a full holding register and is followed by a start bit, that the bit index stays within the character length, that a disabled idle shifter stays idle, and that a held character is never altered except by a write. Other behaviour can only be shown by the bench's scenarios, which drive its reference model on each clock. That covers:
- the exact bit sequence on the line across all lengths, both parity kinds and both stop counts;
- the bit duration in both timing modes;
- the gap-free handoff between frames;
- the ninth-bit capture;
- a disable in the middle of a frame.

// File: rtl/utx_pkg.sv
package utx_pkg;

    // Widest character the shifter carries
    localparam int UTX_MAXW = 9;
    // Width of a bit count 0..UTX_MAXW
    localparam int UTX_CW   = $clog2(UTX_MAXW + 1);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5
    } utx_state_e;

    // Character length from the 3-bit select: 5..8, anything above 3 gives 9
    function automatic logic [UTX_CW-1:0] char_len(input logic [2:0] sel);
        if (sel >= 3'd4) return UTX_CW'(UTX_MAXW);
        return UTX_CW'(5) + UTX_CW'(sel);
    endfunction

endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
    parameter int MAXW = 9,
    parameter int CW   = $clog2(MAXW + 1)
) (
    input  logic [MAXW-1:0] data,
    input  logic [CW-1:0]   nbits,
    input  logic            odd,
    output logic            par
);

    // XOR of the active data bits, seeded with the odd/even constant
    always_comb begin
        par = odd;
        for (int i = 0; i < MAXW; i++) begin
            if (CW'(i) < nbits) par = par ^ data[i];
        end
    end

endmodule

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic sync_mode,
    input  logic baud_tick,
    input  logic sclk_in,
    output logic bit_stb
);

    localparam int               TW    = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [TW-1:0]    TLAST = TW'(OVERSAMPLE - 1);

    logic [TW-1:0]          tick_cnt;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sclk_last;
    logic                   sclk_rise;

    // Synchronizer for the external serial clock
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sclk_in;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_last <= 1'b0;
        else        sclk_last <= sync_q[SYNC_STAGES-1];
    end

    assign sclk_rise = sync_q[SYNC_STAGES-1] & ~sclk_last;

    // Oversampling counter: restarts with each frame, idle while no frame runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (!active || restart) begin
            tick_cnt <= '0;
        end else if (baud_tick) begin
            tick_cnt <= (tick_cnt == TLAST) ? '0 : tick_cnt + TW'(1);
        end
    end

    always_comb begin
        if (!active)        bit_stb = 1'b0;
        else if (sync_mode) bit_stb = sclk_rise;
        else                bit_stb = baud_tick && (tick_cnt == TLAST);
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (bit_stb && (sync_mode || OVERSAMPLE > 1)) |=> !bit_stb); // R3

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                bit_stb,
    input  logic                buf_valid,
    input  logic [UTX_MAXW-1:0] buf_data,
    input  logic [UTX_CW-1:0]   nbits,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic                load,
    output logic                frame_end,
    output logic                active,
    output logic                txd
);

    utx_state_e          state, state_nx;
    logic [UTX_MAXW-1:0] shreg;
    logic [UTX_CW-1:0]   bit_idx;
    logic                par_q;
    logic                par_new;
    logic                last_stop;
    logic                last_data;

    utx_parity #(.MAXW(UTX_MAXW), .CW(UTX_CW)) i_parity (
        .data  (buf_data),
        .nbits (nbits),
        .odd   (par_odd),
        .par   (par_new)
    );

    assign last_stop = (state == ST_STOP2) || (state == ST_STOP1 && !two_stop);
    assign last_data = (bit_idx == nbits - UTX_CW'(1));
    assign frame_end = bit_stb && last_stop;
    assign load      = tx_en && buf_valid && ((state == ST_IDLE) || frame_end);
    assign active    = (state != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (load) state_nx = ST_START;
            ST_START:  if (bit_stb) state_nx = ST_DATA;
            ST_DATA:   if (bit_stb && last_data) state_nx = par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_stb) state_nx = ST_STOP1;
            ST_STOP1:  if (bit_stb) state_nx = two_stop ? ST_STOP2 : (load ? ST_START : ST_IDLE);
            ST_STOP2:  if (bit_stb) state_nx = load ? ST_START : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            par_q   <= 1'b0;
        end else if (load) begin
            shreg   <= buf_data;
            bit_idx <= '0;
            par_q   <= par_new;
        end else if (state == ST_DATA && bit_stb) begin
            shreg   <= {1'b0, shreg[UTX_MAXW-1:1]};
            bit_idx <= bit_idx + UTX_CW'(1);
        end
    end

    // Line output
    always_comb begin
        unique case (state)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            ST_STOP1:  txd = 1'b1;
            ST_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    AST_LOAD_STARTS:  assert property (@(posedge clk) disable iff (!rst_n) load |=> (state == ST_START && !txd)); // R4
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_DATA) |-> (bit_idx < nbits)); // R1
    AST_OFF_STAYS:    assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && state == ST_IDLE) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/utx_holdflags.sv
module utx_holdflags
    import utx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_data,
    input  logic [7:0]          wdata,
    input  logic                wbit8,
    input  logic                load,
    input  logic                frame_end,
    input  logic                st_wr,
    input  logic                st_wdre,
    input  logic                st_wtxc,
    input  logic                txc_ack,
    input  logic                dre_ie,
    input  logic                txc_ie,
    input  logic                gie,
    output logic                buf_valid,
    output logic [UTX_MAXW-1:0] buf_data,
    output logic                dre,
    output logic                txc,
    output logic                irq_dre,
    output logic                irq_txc
);

    logic txc_set;
    logic txc_clr;
    logic dre_clr;

    assign txc_set = frame_end && !buf_valid;
    assign txc_clr = txc_ack || (st_wr && !st_wtxc);
    assign dre_clr = st_wr && !st_wdre;

    // Holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_data  <= '0;
        end else if (wr_data) begin
            buf_valid <= 1'b1;
            buf_data  <= {wbit8, wdata};
        end else if (load) begin
            buf_valid <= 1'b0;
        end
    end

    // Empty flag: write clears, handoff sets, software may only clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dre <= 1'b1;
        else if (wr_data) dre <= 1'b0;
        else if (load)    dre <= 1'b1;
        else if (dre_clr) dre <= 1'b0;
    end

    // Complete flag: set wins over acknowledge and software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       txc <= 1'b0;
        else if (txc_set) txc <= 1'b1;
        else if (txc_clr) txc <= 1'b0;
    end

    assign irq_dre = dre && dre_ie && gie;
    assign irq_txc = txc && txc_ie && gie;

    AST_LOAD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) load |-> buf_valid); // R4
    AST_WR_CLEARS_DRE: assert property (@(posedge clk) disable iff (!rst_n) wr_data |=> !dre); // R6
    AST_DRE_NO_W1:     assert property (@(posedge clk) disable iff (!rst_n) (st_wr && st_wdre && !dre && !load) |=> !dre); // R6
    AST_TXC_SETS:      assert property (@(posedge clk) disable iff (!rst_n) (frame_end && !buf_valid) |=> txc); // R7
    AST_TXC_ACK_CLR:   assert property (@(posedge clk) disable iff (!rst_n) (txc_ack && !(frame_end && !buf_valid)) |=> !txc); // R7
    AST_TXC_NO_W1:     assert property (@(posedge clk) disable iff (!rst_n) (st_wr && st_wtxc && !txc && !frame_end) |=> !txc); // R7
    AST_HOLD_KEEPS:    assert property (@(posedge clk) disable iff (!rst_n) (buf_valid && !load && !wr_data) |=> (buf_valid && $stable(buf_data))); // R10

endmodule

// File: rtl/dbuf_utx.sv
module dbuf_utx
    import utx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       sync_mode,
    input  logic [2:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       baud_tick,
    input  logic       sclk_in,
    input  logic       wr_data,
    input  logic [7:0] wdata,
    input  logic       wbit8,
    input  logic       st_wr,
    input  logic       st_wdre,
    input  logic       st_wtxc,
    input  logic       txc_ack,
    input  logic       dre_ie,
    input  logic       txc_ie,
    input  logic       gie,
    output logic       txd,
    output logic       dre,
    output logic       txc,
    output logic       irq_dre,
    output logic       irq_txc
);

    logic                bit_stb;
    logic                load;
    logic                frame_end;
    logic                active;
    logic                buf_valid;
    logic [UTX_MAXW-1:0] buf_data;
    logic [UTX_CW-1:0]   nbits;

    assign nbits = char_len(len_sel);

    utx_bitclk #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) i_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .restart   (load),
        .sync_mode (sync_mode),
        .baud_tick (baud_tick),
        .sclk_in   (sclk_in),
        .bit_stb   (bit_stb)
    );

    utx_shifter i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .bit_stb   (bit_stb),
        .buf_valid (buf_valid),
        .buf_data  (buf_data),
        .nbits     (nbits),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_stop  (two_stop),
        .load      (load),
        .frame_end (frame_end),
        .active    (active),
        .txd       (txd)
    );

    utx_holdflags i_holdflags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data   (wr_data),
        .wdata     (wdata),
        .wbit8     (wbit8),
        .load      (load),
        .frame_end (frame_end),
        .st_wr     (st_wr),
        .st_wdre   (st_wdre),
        .st_wtxc   (st_wtxc),
        .txc_ack   (txc_ack),
        .dre_ie    (dre_ie),
        .txc_ie    (txc_ie),
        .gie       (gie),
        .buf_valid (buf_valid),
        .buf_data  (buf_data),
        .dre       (dre),
        .txc       (txc),
        .irq_dre   (irq_dre),
        .irq_txc   (irq_txc)
    );

    AST_TXC_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(txc) |-> $past(frame_end)); // R7

endmodule

// File: tb/test_dbuf_utx.sv
module test_dbuf_utx;

    localparam int CLK_P    = 10;
    localparam int OVS      = 16;
    localparam int WDOG_MAX = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, sync_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic [2:0] len_sel = 3'd3;
    logic       baud_tick = 1'b0, sclk_in = 1'b0, sclk_run = 1'b0;
    logic       wr_data = 1'b0, wbit8 = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       st_wr = 1'b0, st_wdre = 1'b1, st_wtxc = 1'b1, txc_ack = 1'b0;
    logic       dre_ie = 1'b0, txc_ie = 1'b0, gie = 1'b0;
    logic       txd, dre, txc, irq_dre, irq_txc;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string scen = "reset";

    dbuf_utx #(.OVERSAMPLE(OVS), .SYNC_STAGES(2)) i_dbuf_utx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sync_mode(sync_mode), .len_sel(len_sel),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .baud_tick(baud_tick),
        .sclk_in(sclk_in), .wr_data(wr_data), .wdata(wdata), .wbit8(wbit8), .st_wr(st_wr),
        .st_wdre(st_wdre), .st_wtxc(st_wtxc), .txc_ack(txc_ack), .dre_ie(dre_ie),
        .txc_ie(txc_ie), .gie(gie), .txd(txd), .dre(dre), .txc(txc), .irq_dre(irq_dre),
        .irq_txc(irq_txc)
    );

    always #(CLK_P/2) clk = ~clk;

    // Baud tick every second cycle; serial clock toggles every third cycle when running
    always @(posedge clk) begin
        #(CLK_P/4);
        baud_tick = (cycles % 2 == 0);
        if (sclk_run && (cycles % 3 == 0)) sclk_in = ~sclk_in;
    end

    // ---------------- reference model ----------------
    bit       m_idle = 1'b1;
    bit       m_q[$];
    int       m_ticks = 0;
    bit       m_bv = 1'b0;
    bit [8:0] m_buf = '0;
    bit       m_dre = 1'b1;
    bit       m_txc = 1'b0;
    bit       m_s1 = 1'b0, m_s2 = 1'b0, m_sd = 1'b0;

    function automatic int m_len(input logic [2:0] sel);
        return (sel >= 3'd4) ? 9 : 5 + int'(sel);
    endfunction

    always @(posedge clk) begin : model
        bit stb, fend, ld, tset, rise;
        cycles++;
        if (!rst_n) begin
            m_idle = 1'b1; m_q.delete(); m_ticks = 0; m_bv = 1'b0; m_buf = '0;
            m_dre = 1'b1; m_txc = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_sd = 1'b0;
        end else begin
            rise = m_s2 && !m_sd;
            stb  = !m_idle && (sync_mode ? rise : (baud_tick && m_ticks == OVS - 1));
            fend = stb && (m_q.size() == 1);
            ld   = tx_en && m_bv && (m_idle || fend);
            tset = fend && !m_bv;
            if (stb) void'(m_q.pop_front());
            if (m_idle || ld)              m_ticks = 0;
            else if (baud_tick)            m_ticks = (m_ticks + 1) % OVS;
            if (ld) begin
                int n;
                bit p;
                n = m_len(len_sel);
                p = par_odd;
                m_q.delete();
                m_q.push_back(1'b0);
                for (int i = 0; i < n; i++) begin
                    m_q.push_back(m_buf[i]);
                    p = p ^ m_buf[i];
                end
                if (par_en)   m_q.push_back(p);
                m_q.push_back(1'b1);
                if (two_stop) m_q.push_back(1'b1);
                m_idle = 1'b0;
            end else if (fend) begin
                m_idle = 1'b1;
            end
            if (wr_data) begin
                m_buf = {wbit8, wdata};
                m_bv  = 1'b1;
            end else if (ld) begin
                m_bv = 1'b0;
            end
            if (wr_data)                m_dre = 1'b0;
            else if (ld)                m_dre = 1'b1;
            else if (st_wr && !st_wdre) m_dre = 1'b0;
            if (tset)                                m_txc = 1'b1;
            else if (txc_ack || (st_wr && !st_wtxc)) m_txc = 1'b0;
            m_sd = m_s2; m_s2 = m_s1; m_s1 = sclk_in;
        end
    end

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s [%s] got %0b expected %0b at %0t", req, what, scen, got, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "txd", txd, m_idle ? 1'b1 : m_q[0]);
            chk("R6", "dre", dre, m_dre);
            chk("R7", "txc", txc, m_txc);
            chk("R8", "irq_dre", irq_dre, m_dre & dre_ie & gie);
            chk("R8", "irq_txc", irq_txc, m_txc & txc_ie & gie);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic put(input logic [7:0] d, input logic b8);
        wdata = d; wbit8 = b8; wr_data = 1'b1;
        step(1);
        wr_data = 1'b0;
        wbit8 = ~b8;   // R5: later changes must not reach the held character
    endtask

    task automatic drain;
        for (int k = 0; k < 20000; k++) begin
            if (m_idle && !m_bv) break;
            step(1);
        end
        step(3);
    endtask

    task automatic stat(input logic wd, input logic wt);
        st_wdre = wd; st_wtxc = wt; st_wr = 1'b1;
        step(1);
        st_wr = 1'b0; st_wdre = 1'b1; st_wtxc = 1'b1;
    endtask

    // Watchdog
    initial begin
        wait (cycles >= WDOG_MAX);
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        @(negedge clk);
        chk("R9", "reset txd", txd, 1'b1);
        chk("R6", "reset dre", dre, 1'b1);
        chk("R7", "reset txc", txc, 1'b0);
        step(1);

        scen = "R1 8N1";
        tx_en = 1'b1; dre_ie = 1'b1; txc_ie = 1'b1; gie = 1'b1;
        put(8'hA5, 1'b0);
        step(1);
        @(negedge clk);
        chk("R4", "start after idle load", txd, 1'b0);
        step(1);
        drain();
        @(negedge clk);
        chk("R7", "txc after frame", txc, 1'b1);
        chk("R8", "irq_txc raised", irq_txc, 1'b1);
        step(1);

        scen = "R4 back-to-back";
        put(8'h3C, 1'b0);
        step(2);
        put(8'hC3, 1'b0);
        drain();

        scen = "R2 even 7E2";
        len_sel = 3'd2; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
        put(8'h5B, 1'b0); drain();
        scen = "R2 odd 7O2";
        par_odd = 1'b1;
        put(8'h5B, 1'b0); put(8'h11, 1'b0); drain();

        scen = "R5 nine bits";
        len_sel = 3'd4; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
        put(8'h0F, 1'b1); drain();
        put(8'hF0, 1'b0); drain();

        scen = "R1 five bits";
        len_sel = 3'd0; par_en = 1'b0;
        put(8'h15, 1'b0); put(8'h0A, 1'b0); drain();

        scen = "R7 txc clear";
        stat(1'b1, 1'b1);
        @(negedge clk);
        chk("R7", "write 1 keeps txc", txc, 1'b1);
        step(1);
        stat(1'b1, 1'b0);
        @(negedge clk);
        chk("R7", "write 0 clears txc", txc, 1'b0);
        step(1);
        put(8'h77, 1'b0); drain();
        txc_ack = 1'b1; step(1); txc_ack = 1'b0;
        @(negedge clk);
        chk("R7", "ack clears txc", txc, 1'b0);
        step(1);

        scen = "R6 R10 disabled buffer";
        tx_en = 1'b0; len_sel = 3'd3;
        put(8'h12, 1'b0);
        put(8'h34, 1'b0);
        stat(1'b1, 1'b1);
        @(negedge clk);
        chk("R6", "write 1 keeps dre low", dre, 1'b0);
        chk("R9", "line high while disabled", txd, 1'b1);
        step(40);
        @(negedge clk);
        chk("R9", "no start while disabled", txd, 1'b1);
        step(1);
        tx_en = 1'b1;
        drain();
        stat(1'b0, 1'b1);
        @(negedge clk);
        chk("R6", "write 0 clears dre", dre, 1'b0);
        step(1);

        scen = "R8 gating";
        gie = 1'b0; put(8'h01, 1'b0); drain();
        gie = 1'b1; txc_ie = 1'b0; dre_ie = 1'b1; put(8'h80, 1'b0); drain();
        txc_ie = 1'b1;

        scen = "R9 disable mid-frame";
        put(8'h96, 1'b0);
        step(60);
        tx_en = 1'b0;
        put(8'h69, 1'b0);
        for (int k = 0; k < 400; k++) begin
            if (m_idle) break;
            step(1);
        end
        step(50);
        @(negedge clk);
        chk("R9", "held char waits", txd, 1'b1);
        step(1);
        tx_en = 1'b1;
        drain();

        scen = "R3 sync mode";
        sync_mode = 1'b1; sclk_run = 1'b1; par_en = 1'b1; par_odd = 1'b1;
        put(8'hE7, 1'b0); put(8'h18, 1'b0); drain();
        sclk_run = 1'b0; sync_mode = 1'b0;
        step(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule